// File: doc/BRIEF.md
# Dual-Channel Edge Event Capture Timer

The block times intervals between edges on two input pins. A shared 16-bit counter advances once every DIV system clocks, where DIV is a software-set divisor. Each pin feeds its own channel. A channel records the counter value at three moments: the first A event, the following B event and the next A event. A and B are each a rising or falling edge on that channel's pin, chosen per channel. Software subtracts these captured values to get period, on-time or duty cycle.

A channel finishes its sequence either at the B event or at the second A event, chosen per channel. When it finishes, it sets its status bit and raises the shared interrupt. Reading the status register clears it. In single-shot mode a finished channel halts until software re-arms it. In free-running mode the channel re-arms itself and starts watching for a new first A at once. The pins are asynchronous and pass through a two-flop synchronizer before edge detection.

The register port is a simple single-cycle bus. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr` while `bus_rd` is high. A read of the status register clears it at that same edge.

Top module: `edge_capture_timer`

## Requirements
- R1: The counter increases by one every DIV clock cycles. DIV is held at address 0, resets to 1, and a value of 0 acts as 1. Writing DIV restarts the divide phase.
- R2: Address 1 returns the live counter value. A write to address 1 has no effect.
- R3: Address 2 holds the configuration, and channel c uses bits 4c to 4c+3. Bit 4c chooses event A polarity and bit 4c+1 chooses event B polarity, where 1 is rising and 0 is falling.
- R4: A channel stores the counter value at the first A event at address 8+4c, at the following B event at address 9+4c, and at the next A event at address 10+4c.
- R5: When bit 4c+2 is 1, the sequence completes at B and the second-A capture is left unchanged. When that bit is 0, the sequence completes at the second A event.
- R6: `irq` is high for one cycle, in the cycle after each cycle in which any channel completes. When both channels complete in the same cycle, there is a single one-cycle pulse.
- R7: Status bit c at address 4 is set when channel c completes. A read returns the bits and clears them. If a completion falls in the cycle of the clearing read, its bit stays set.
- R8: When bit 4c+3 is 0 (single-shot), a completed channel halts, ignores all pin edges and leaves its captures unchanged. Writing 1 to bit c of address 3 re-arms it. Address 3 reads back one bit per channel, 1 when the channel is armed.
- R9: When bit 4c+3 is 1 (free-running), a channel re-arms itself on completion and stays armed. The completing edge does not count as the next first A event.
- R10: A pin change set up before clock edge k has its capture, status and completion take effect at edge k+2.
- R11: After reset, DIV reads 1, configuration, status and armed bits read 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pin | input | NUM_CH | Asynchronous event pins, one per channel |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe, which clears status at address 4 |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| irq | output | 1 | Shared completion pulse |

## Verification
The bench drives edges at known cycle spacings and compares the differences between captured values with those spacings divided by DIV. This catches a slot that latches at the wrong event, or a divider that is off by one. It checks several cases:
- A halted single-shot channel receives a burst of edges. A design that kept capturing would change the stored values or pulse `irq`.
- Both channels complete in the same cycle. A design that did this wrongly would give two pulses or lose a status bit.
- A status read lands exactly on a completion edge. A clear-wins design would lose that bit.
- A free-running channel runs two back-to-back sequences. The second sequence's captured differences expose a design that reuses the completing edge as the next start.

// File: rtl/ect_pkg.sv
package ect_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Per-channel configuration nibble; bit 0 of the nibble is a_rise.
  typedef struct packed {
    logic free_run;   // nibble bit 3
    logic end_on_b;   // nibble bit 2
    logic b_rise;     // nibble bit 1
    logic a_rise;     // nibble bit 0
  } ch_cfg_t;

  localparam int CFG_BITS_PER_CH = 4;
  localparam int SLOTS_PER_CH    = 3;

  typedef enum logic [1:0] {
    CH_HALT    = 2'd0,
    CH_WAIT_A1 = 2'd1,
    CH_WAIT_B  = 2'd2,
    CH_WAIT_A2 = 2'd3
  } ch_state_e;

  // Register addresses
  localparam int ADR_DIV      = 0;
  localparam int ADR_TIMER    = 1;
  localparam int ADR_CFG      = 2;
  localparam int ADR_CTRL     = 3;
  localparam int ADR_STAT     = 4;
  localparam int ADR_CAP_BASE = 8;

  // Capture slot numbering: 0 first A, 1 B, 2 second A
  function automatic int cap_addr(input int ch, input int slot);
    return ADR_CAP_BASE + CFG_BITS_PER_CH * ch + slot;
  endfunction

  function automatic logic pick_edge(input logic want_rise, input logic rise,
                                     input logic fall);
    return want_rise ? rise : fall;
  endfunction

  function automatic ch_state_e state_after_done(input logic free_run);
    return free_run ? CH_WAIT_A1 : CH_HALT;
  endfunction
endpackage

// File: rtl/ect_timebase.sv
module ect_timebase #(
  parameter int TIMER_W = 16,
  parameter int DIV_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   div,
  input  logic               div_load,
  output logic [TIMER_W-1:0] timer,
  output logic               tick
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [DIV_W-1:0] pre_cnt;

  // Last phase of a divide period; a divisor of zero behaves as one.
  function automatic logic last_phase(input logic [DIV_W-1:0] cnt,
                                      input logic [DIV_W-1:0] dv);
    if (dv == '0) return 1'b1;
    return cnt >= (dv - 1'b1);
  endfunction

  assign tick = last_phase(pre_cnt, div) && !div_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      timer   <= '0;
    end else if (div_load) begin
      pre_cnt <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
      timer   <= timer + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ect_edge_sync.sv
module ect_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      prev  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/ect_channel.sv
module ect_channel
  import ect_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ch_cfg_t            cfg,
  input  logic               restart,
  input  logic               rise,
  input  logic               fall,
  input  logic [TIMER_W-1:0] timer,
  output logic               armed,
  output logic               done,
  output logic [2:0]         cap_en,
  output logic [TIMER_W-1:0] cap_a1,
  output logic [TIMER_W-1:0] cap_b,
  output logic [TIMER_W-1:0] cap_a2
);
  timeunit 1ns;
  timeprecision 1ps;

  ch_state_e state_q, state_d;
  logic      ev_a, ev_b;

  assign ev_a = pick_edge(cfg.a_rise, rise, fall);
  assign ev_b = pick_edge(cfg.b_rise, rise, fall);

  always_comb begin
    state_d = state_q;
    done    = 1'b0;
    cap_en  = 3'b000;
    if (restart) begin
      state_d = CH_WAIT_A1;
    end else begin
      unique case (state_q)
        CH_HALT: state_d = CH_HALT;
        CH_WAIT_A1: if (ev_a) begin
          cap_en[0] = 1'b1;
          state_d   = CH_WAIT_B;
        end
        CH_WAIT_B: if (ev_b) begin
          cap_en[1] = 1'b1;
          if (cfg.end_on_b) begin
            done    = 1'b1;
            state_d = state_after_done(cfg.free_run);
          end else begin
            state_d = CH_WAIT_A2;
          end
        end
        CH_WAIT_A2: if (ev_a) begin
          cap_en[2] = 1'b1;
          done      = 1'b1;
          state_d   = state_after_done(cfg.free_run);
        end
        default: state_d = CH_HALT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_HALT;
      cap_a1  <= '0;
      cap_b   <= '0;
      cap_a2  <= '0;
    end else begin
      state_q <= state_d;
      if (cap_en[0]) cap_a1 <= timer;
      if (cap_en[1]) cap_b  <= timer;
      if (cap_en[2]) cap_a2 <= timer;
    end
  end

  assign armed = (state_q != CH_HALT);
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
  import ect_pkg::*;
#(
  parameter int TIMER_W     = 16,
  parameter int DIV_W       = 16,
  parameter int DATA_W      = 16,
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(ADR_CAP_BASE + CFG_BITS_PER_CH * NUM_CH),
  localparam int CFG_W      = CFG_BITS_PER_CH * NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt_pin,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  timeunit 1ns;
  timeprecision 1ps;

  // Named internal events, observed by the bound checker
  logic               tick_w;
  logic [TIMER_W-1:0] timer_w;
  logic [NUM_CH-1:0]  done_w, armed_w, free_w, restart_w, cap_any_w;
  logic [NUM_CH-1:0]  stat_q;
  logic               stat_rd_w, div_wr_w, cfg_wr_w, ctrl_wr_w;

  logic [DIV_W-1:0]   div_q;
  logic [CFG_W-1:0]   cfg_q;
  logic [TIMER_W-1:0] cap_mat [NUM_CH][SLOTS_PER_CH];

  assign div_wr_w  = bus_wr && (bus_addr == ADDR_W'(ADR_DIV));
  assign cfg_wr_w  = bus_wr && (bus_addr == ADDR_W'(ADR_CFG));
  assign ctrl_wr_w = bus_wr && (bus_addr == ADDR_W'(ADR_CTRL));
  assign stat_rd_w = bus_rd && (bus_addr == ADDR_W'(ADR_STAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(1);
      cfg_q <= '0;
    end else begin
      if (div_wr_w) div_q <= bus_wdata[DIV_W-1:0];
      if (cfg_wr_w) cfg_q <= bus_wdata[CFG_W-1:0];
    end
  end

  ect_timebase #(
    .TIMER_W(TIMER_W),
    .DIV_W  (DIV_W)
  ) u_timebase (
    .clk     (clk),
    .rst_n   (rst_n),
    .div     (div_q),
    .div_load(div_wr_w),
    .timer   (timer_w),
    .tick    (tick_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic    rise, fall;
    logic [2:0] cap_en;
    ch_cfg_t ccfg;

    assign ccfg         = ch_cfg_t'(cfg_q[c*CFG_BITS_PER_CH +: CFG_BITS_PER_CH]);
    assign free_w[c]    = ccfg.free_run;
    assign restart_w[c] = ctrl_wr_w && bus_wdata[c];
    assign cap_any_w[c] = |cap_en;

    ect_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (evt_pin[c]),
      .rise (rise),
      .fall (fall)
    );

    ect_channel #(.TIMER_W(TIMER_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg    (ccfg),
      .restart(restart_w[c]),
      .rise   (rise),
      .fall   (fall),
      .timer  (timer_w),
      .armed  (armed_w[c]),
      .done   (done_w[c]),
      .cap_en (cap_en),
      .cap_a1 (cap_mat[c][0]),
      .cap_b  (cap_mat[c][1]),
      .cap_a2 (cap_mat[c][2])
    );
  end

  // Status: a completion in the same cycle as the clearing read wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= done_w | (stat_q & {NUM_CH{!stat_rd_w}});
      irq    <= |done_w;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(ADR_DIV))   bus_rdata = DATA_W'(div_q);
    if (bus_addr == ADDR_W'(ADR_TIMER)) bus_rdata = DATA_W'(timer_w);
    if (bus_addr == ADDR_W'(ADR_CFG))   bus_rdata = DATA_W'(cfg_q);
    if (bus_addr == ADDR_W'(ADR_CTRL))  bus_rdata = DATA_W'(armed_w);
    if (bus_addr == ADDR_W'(ADR_STAT))  bus_rdata = DATA_W'(stat_q);
    for (int c = 0; c < NUM_CH; c++) begin
      for (int s = 0; s < SLOTS_PER_CH; s++) begin
        if (bus_addr == ADDR_W'(cap_addr(c, s))) bus_rdata = DATA_W'(cap_mat[c][s]);
      end
    end
  end
endmodule

// File: rtl/ect_checker.sv
module ect_checker #(
  parameter int NUM_CH  = 2,
  parameter int TIMER_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic [TIMER_W-1:0] timer,
  input logic [NUM_CH-1:0]  done,
  input logic [NUM_CH-1:0]  armed,
  input logic [NUM_CH-1:0]  free_run,
  input logic [NUM_CH-1:0]  restart,
  input logic [NUM_CH-1:0]  cap_any,
  input logic [NUM_CH-1:0]  stat,
  input logic               stat_rd,
  input logic               irq
);
  timeunit 1ns;
  timeprecision 1ps;

  a_r1_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> timer == TIMER_W'($past(timer) + 1'b1));

  a_r1_timer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(timer));

  a_r6_irq_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (|done) |=> irq);

  a_r6_irq_only_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|done));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    a_r7_status_sets: assert property (@(posedge clk) disable iff (!rst_n)
      done[c] |=> stat[c]);

    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !done[c]) |=> !stat[c]);

    a_r8_halted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !armed[c] |-> (!done[c] && !cap_any[c]));

    a_r8_single_halts: assert property (@(posedge clk) disable iff (!rst_n)
      (done[c] && !free_run[c]) |=> !armed[c]);

    a_r9_free_rearms: assert property (@(posedge clk) disable iff (!rst_n)
      (done[c] && free_run[c]) |=> armed[c]);

    a_r8_restart_arms: assert property (@(posedge clk) disable iff (!rst_n)
      restart[c] |=> armed[c]);
  end
endmodule

bind edge_capture_timer ect_checker #(
  .NUM_CH (NUM_CH),
  .TIMER_W(TIMER_W)
) u_ect_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick_w),
  .timer   (timer_w),
  .done    (done_w),
  .armed   (armed_w),
  .free_run(free_w),
  .restart (restart_w),
  .cap_any (cap_any_w),
  .stat    (stat_q),
  .stat_rd (stat_rd_w),
  .irq     (irq)
);

// File: tb/test_edge_capture_timer.sv
module test_edge_capture_timer;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  pins = 2'b00;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  edge_capture_timer i_edge_capture_timer (
    .clk(clk), .rst_n(rst_n), .evt_pin(pins), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  int  cyc = 0, irq_cnt = 0, n_tests = 0, n_fail = 0;
  bit  finished = 0;

  always @(posedge clk) cyc++;
  always @(negedge clk) if (irq) irq_cnt++;

  typedef struct { int ch; int d_b; int d_aa; bit end_b; } exp_t;
  exp_t sbq[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [15:0] d, output int c);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata; c = cyc;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  function automatic logic [3:0] cap_adr(input int ch, input int slot);
    return 4'(8 + 4 * ch + slot);
  endfunction

  // Driver: pushes the expected capture spacing, then drives A, B (, A).
  task automatic run_seq(input int ch, input bit a_lvl, input int p, input int q,
                         input bit end_b, input int dv);
    exp_t e;
    e.ch = ch; e.d_b = p / dv; e.d_aa = (p + q) / dv; e.end_b = end_b;
    sbq.push_back(e);
    @(negedge clk); pins[ch] = a_lvl;
    repeat (p - 1) @(negedge clk);
    @(negedge clk); pins[ch] = !a_lvl;
    if (!end_b) begin
      repeat (q - 1) @(negedge clk);
      @(negedge clk); pins[ch] = a_lvl;
    end
    repeat (4) @(negedge clk);
  endtask

  // Checker side of the scoreboard: pop and compare captured differences.
  task automatic check_seq(input string tag);
    exp_t e;
    logic [15:0] a1, b, aa;
    int c;
    e = sbq.pop_front();
    bus_read(cap_adr(e.ch, 0), a1, c);
    bus_read(cap_adr(e.ch, 1), b, c);
    chk({tag, " R4 B-A1"}, 32'(16'(b - a1)), 32'(e.d_b));
    if (!e.end_b) begin
      bus_read(cap_adr(e.ch, 2), aa, c);
      chk({tag, " R4 A2-A1"}, 32'(16'(aa - a1)), 32'(e.d_aa));
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] d, t0, t1, s_a1, s_b, s_aa;
    int c0, c1, c, irq0;

    repeat (4) @(negedge clk);
    #1 chk("R11 irq low in reset", 32'(irq), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11 reset state
    bus_read(4'd0, d, c); chk("R11 divisor reset", 32'(d), 1);
    bus_read(4'd2, d, c); chk("R11 config reset", 32'(d), 0);
    bus_read(4'd4, d, c); chk("R11 status reset", 32'(d), 0);
    bus_read(4'd3, d, c); chk("R11 armed reset", 32'(d), 0);

    // R1/R2 timer at divide-by-one; write to timer address ignored
    bus_read(4'd1, t0, c0);
    bus_write(4'd1, 16'h1234);
    repeat (6) @(posedge clk);
    bus_read(4'd1, t1, c1);
    chk("R2 timer tracks cycles, write ignored", 32'(16'(t1 - t0)), 32'(c1 - c0));

    // R1 divide by 4 over a multiple of 4 cycles
    bus_write(4'd0, 16'd4);
    bus_read(4'd1, t0, c0);
    repeat (39) @(posedge clk);
    bus_read(4'd1, t1, c1);
    chk("R1 divide-by-4 window cycles", 32'((c1 - c0) % 4), 0);
    chk("R1 divide-by-4 ticks", 32'(16'(t1 - t0)), 32'((c1 - c0) / 4));

    // S1: ch0 single-shot, A rise, B fall, end on second A
    bus_write(4'd0, 16'd1);
    bus_write(4'd2, 16'h0001);
    bus_write(4'd3, 16'h0001);
    bus_read(4'd3, d, c); chk("R8 restart arms ch0", 32'(d), 1);
    irq0 = irq_cnt;
    run_seq(0, 1'b1, 7, 5, 1'b0, 1);
    chk("R6 one pulse per completion", 32'(irq_cnt - irq0), 1);
    bus_read(4'd4, d, c); chk("R7 status ch0 set", 32'(d), 1);
    bus_read(4'd4, d, c); chk("R7 status cleared by read", 32'(d), 0);
    check_seq("S1 R5 end on A2");
    bus_read(4'd3, d, c); chk("R8 single-shot halts", 32'(d), 0);

    // S2: halted channel ignores edges
    bus_read(cap_adr(0, 0), s_a1, c);
    bus_read(cap_adr(0, 1), s_b, c);
    bus_read(cap_adr(0, 2), s_aa, c);
    irq0 = irq_cnt;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); pins[0] = ~pins[0];
      repeat (3) @(negedge clk);
    end
    chk("R8 no irq while halted", 32'(irq_cnt - irq0), 0);
    bus_read(cap_adr(0, 0), d, c); chk("R8 first-A capture unchanged", 32'(d), 32'(s_a1));
    bus_read(cap_adr(0, 1), d, c); chk("R8 B capture unchanged", 32'(d), 32'(s_b));
    bus_read(4'd4, d, c); chk("R8 no status while halted", 32'(d), 0);

    // S3: ch0 end on B, divide by 2
    @(negedge clk); pins[0] = 1'b0;
    repeat (4) @(negedge clk);
    bus_write(4'd0, 16'd2);
    bus_write(4'd2, 16'h0005);
    bus_write(4'd3, 16'h0001);
    irq0 = irq_cnt;
    run_seq(0, 1'b1, 6, 0, 1'b1, 2);
    chk("R6 end-on-B pulse", 32'(irq_cnt - irq0), 1);
    bus_read(4'd4, d, c); chk("R5 status on B completion", 32'(d), 1);
    check_seq("S3 R1 R5 end on B");
    bus_read(cap_adr(0, 2), d, c); chk("R5 second-A slot untouched", 32'(d), 32'(s_aa));

    // S4: ch1 free-running, A fall, B rise, end on B (cfg nibble 0xE)
    bus_write(4'd0, 16'd1);
    bus_write(4'd2, 16'h00E5);
    @(negedge clk); pins[1] = 1'b1;
    repeat (4) @(negedge clk);
    bus_write(4'd3, 16'h0002);
    irq0 = irq_cnt;
    run_seq(1, 1'b0, 9, 0, 1'b1, 1);
    bus_read(4'd4, d, c); chk("R3 R7 falling-A channel status bit 1", 32'(d), 2);
    bus_read(4'd3, d, c); chk("R9 free-running stays armed", 32'(d[1]), 1);
    check_seq("S4a R3");
    run_seq(1, 1'b0, 4, 0, 1'b1, 1);
    chk("R9 second sequence without restart", 32'(irq_cnt - irq0), 2);
    check_seq("S4b R9");
    bus_read(4'd4, d, c);

    // S5: ch1 free-running, end on second A; completing edge not reused
    bus_write(4'd2, 16'h00A5);
    irq0 = irq_cnt;
    run_seq(1, 1'b0, 3, 4, 1'b0, 1);
    check_seq("S5a R9");
    @(negedge clk); pins[1] = 1'b1;      // B-polarity edge while waiting for A: ignored
    repeat (3) @(negedge clk);
    run_seq(1, 1'b0, 2, 6, 1'b0, 1);
    chk("R9 two free-running completions", 32'(irq_cnt - irq0), 2);
    check_seq("S5b R9 fresh first A");
    bus_read(4'd4, d, c);

    // S6: both channels complete in the same cycle
    bus_write(4'd2, 16'h00E5);
    @(negedge clk); pins[1] = 1'b1;
    repeat (4) @(negedge clk);
    bus_write(4'd3, 16'h0001);
    irq0 = irq_cnt;
    fork
      run_seq(0, 1'b1, 5, 0, 1'b1, 1);
      run_seq(1, 1'b0, 5, 0, 1'b1, 1);
    join
    chk("R6 single pulse for joint completion", 32'(irq_cnt - irq0), 1);
    bus_read(4'd4, d, c); chk("R7 both status bits", 32'(d), 3);
    check_seq("S6 ch0");
    check_seq("S6 ch1");

    // S7: status read in the same cycle as a completion (R10 latency of two edges)
    bus_write(4'd3, 16'h0001);
    @(negedge clk); pins[0] = 1'b1;
    repeat (3) @(negedge clk);
    @(negedge clk); pins[0] = 1'b0;      // B set up before edge k
    @(negedge clk);                      // before edge k+1
    @(negedge clk); bus_rd = 1'b1; bus_addr = 4'd4;   // read clears at edge k+2
    #1 chk("R10 not complete before edge k+2", 32'(bus_rdata), 0);
    @(posedge clk); #1 bus_rd = 1'b0;
    bus_read(4'd4, d, c); chk("R7 R10 completion beats clearing read", 32'(d), 1);

    finished = 1;
    summary();
    $finish;
  end
endmodule